// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave-side command engine of a small serial data memory reached over a four-wire SPI link (active-low select, serial clock, data in, data out). The host lowers select, shifts an 8-bit command, optionally a 16-bit address and data bytes, then raises select to end the frame. The block holds the storage array as plain registers and accepts six commands: array read, array write, status read, status write, latch set and latch clear.

All pins are brought into the system clock domain through a synchronizer and handled with edge detection, so the serial clock must run well below the system clock (at least six system cycles per serial half period). Every change to the array or the status lock field passes through a write-protection scheme. A latch must be set in a frame of its own. Writes are collected in a one-page buffer and land only when select rises at the end of a well-formed frame. Completing a write clears the latch again. A two-bit lock field makes a region of the array read-only.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the data-out enable is low, the status byte reads 0x00 and every array byte reads 0x00.
- R2: SPI mode 0: SI is sampled on rising SCK and SO changes only on falling SCK. The data-out enable is high only while status or array data is being shifted out. It is low while select is high, during command and address bits, and during write data, so SI and SO may share one wire.
- R3: Opcodes are 0x03 read, 0x02 write, 0x05 status read, 0x01 status write, 0x06 latch set, 0x04 latch clear. Any other first byte makes the block ignore the rest of the frame.
- R4: A read is the opcode, a 16-bit address MSB first (low bits select the byte), then data MSB first for as long as SCK runs. The address increments after each byte and wraps from the last byte to byte 0.
- R5: The status byte has bit 0 = 0, bit 1 = write-enable latch, bits 3:2 = lock field, bits 7:4 = 0. It repeats for every extra byte clocked in a status read.
- R6: The latch is set when select rises after a frame of exactly eight bits carrying 0x06. Any further bit in that frame prevents the set.
- R7: Opcode 0x04 clears the latch, and a write sent after it changes nothing.
- R8: A write frame (opcode, 16 address bits, one or more whole bytes) commits at the rising edge of select. Bytes fill a 16-byte page from the given offset and wrap inside that page; a slot written twice keeps the later byte.
- R9: A write with the latch clear, or one whose select rises mid-byte, mid-address or before any data byte, changes no array byte and leaves the latch as it was.
- R10: A committed array write or status write clears the latch.
- R11: Lock field 00 protects nothing, 01 the top quarter, 10 the top half, 11 the whole array. Protected bytes are left unchanged by a write even when the latch is set.
- R12: A status write changes only the lock field, taking it from bits 3:2 of the last whole data byte, and only when the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from host to block |
| so | output | 1 | Serial data to host, 0 when not enabled |
| so_en | output | 1 | Output enable for the SO pad driver (high-impedance when low) |

## Verification
The bench goes after the frame-shape rules of the protection scheme. It sends a latch-set frame with a ninth bit, writes cut off mid-byte, after half an address and with no data byte, and a write after a latch clear. A design that checked only the opcode would corrupt the array or set the latch in those cases. Page wrap and overlapping page writes catch a buffer that spills into the next page or keeps the first value written. A read running past the last byte catches a missing address wrap. A sweep of all four lock settings over the whole array catches a wrong region boundary, and junk in the other status bits catches a status write that stores more than the lock field.

// File: rtl/spi_mem_pkg.sv
// Shared opcodes and frame states for the SPI serial memory slave.
package spi_mem_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_RDATA, ST_WDATA,
        ST_RDSR, ST_WRSR, ST_WREN, ST_SKIP
    } spi_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings cs_n, sck and si into the clk domain and flags select and clock edges.
// Assumes the pins are steady for several clk cycles around each change.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic cs_n_s,
    output logic si_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall
);
    localparam logic [2:0] RST_VAL = 3'b100;

    logic [2:0] raw;
    logic [2:0] synced;
    logic       sck_d;
    logic       cs_d;

    assign raw = {cs_n, sck, si};

    for (genvar g = 0; g < 3; g++) begin : g_sync
        logic [STAGES-1:0] pipe;
        // Shift register synchronizer for one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign synced[g] = pipe[STAGES-1];
    end

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= synced[1];
            cs_d  <= synced[2];
        end
    end

    assign cs_n_s   = synced[2];
    assign si_s     = synced[0];
    assign sck_rise = synced[1] & ~sck_d;
    assign sck_fall = ~synced[1] & sck_d;
    assign cs_rise  = synced[2] & ~cs_d;
    assign cs_fall  = ~synced[2] & cs_d;
endmodule

// File: rtl/spi_page_buf.sv
// One-page write buffer: collects data bytes by page offset with a valid bit each.
// Assumes clr comes at the start of every frame.
module spi_page_buf #(
    parameter int PAGE_W = 4,
    localparam int PAGE = 1 << PAGE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       we,
    input  logic [PAGE_W-1:0]          off,
    input  logic [7:0]                 din,
    output logic [PAGE-1:0][7:0]       data,
    output logic [PAGE-1:0]            valid
);
    // Store a byte at its offset and remember that the slot holds data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (we) begin
            data[off]  <= din;
            valid[off] <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_lock_check.sv
// Decides whether a page lies in the region marked read-only by the lock field.
// Assumes pages never straddle a quarter boundary (at least four pages).
module spi_lock_check (
    input  logic [1:0] lock,
    input  logic [1:0] top2,
    output logic       prot
);
    // Map lock code and the two top address bits to a protect flag.
    always_comb begin
        unique case (lock)
            2'b00:   prot = 1'b0;
            2'b01:   prot = (top2 == 2'b11);
            2'b10:   prot = top2[1];
            default: prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_mem_slave.sv
// SPI mode-0 serial memory slave: command decode, read streaming, status
// register, write-enable latch, block lock and page-buffered array writes.
// Assumes SCK half periods of at least six clk cycles and ADDR_W >= PAGE_W + 2.
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_en
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PAGE    = 1 << PAGE_W;
    localparam int PGSEL_W = ADDR_W - PAGE_W;

    logic              cs_n_s, si_s, sck_rise, sck_fall, cs_rise, cs_fall;
    spi_state_t        state;
    logic [2:0]        bit_cnt;
    logic [3:0]        ab_cnt;
    logic [6:0]        sh_in;
    logic [7:0]        tx_sr;
    logic [7:0]        nb;
    logic              so_q, is_wr, wel, sr_have;
    logic [1:0]        lock_q, sr_new;
    logic [ADDR_W-2:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    logic [ADDR_W-1:0] rd_addr;
    logic [PGSEL_W-1:0] wr_page;
    logic [PAGE_W-1:0] wr_off;
    logic [7:0]        mem [DEPTH];
    logic [7:0]        status;
    logic              byte_done, commit_wr, commit_sr, wren_ok, page_prot, pb_we;
    logic [PAGE-1:0][7:0] pb_data;
    logic [PAGE-1:0]   pb_valid;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .cs_n_s(cs_n_s), .si_s(si_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_fall(cs_fall)
    );

    spi_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(cs_fall), .we(pb_we), .off(wr_off),
        .din(nb), .data(pb_data), .valid(pb_valid)
    );

    spi_lock_check u_lock (
        .lock(lock_q), .top2(wr_page[PGSEL_W-1 -: 2]), .prot(page_prot)
    );

    assign nb        = {sh_in, si_s};
    assign addr_next = {addr_q, si_s};
    assign status    = {4'b0000, lock_q, wel, 1'b0};
    assign byte_done = sck_rise && !cs_n_s && (bit_cnt == 3'd7);
    assign pb_we     = byte_done && (state == ST_WDATA);
    assign wren_ok   = cs_rise && (state == ST_WREN);
    assign commit_wr = cs_rise && wel && (state == ST_WDATA) && (bit_cnt == 3'd0) && (|pb_valid);
    assign commit_sr = cs_rise && wel && (state == ST_WRSR) && (bit_cnt == 3'd0) && sr_have;
    assign so_en     = !cs_n_s && ((state == ST_RDATA) || (state == ST_RDSR));
    assign so        = so_en ? so_q : 1'b0;

    // Frame engine: decode, address capture, read streaming and latch/lock updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            ab_cnt  <= '0;
            sh_in   <= '0;
            tx_sr   <= '0;
            so_q    <= 1'b0;
            is_wr   <= 1'b0;
            wel     <= 1'b0;
            sr_have <= 1'b0;
            lock_q  <= '0;
            sr_new  <= '0;
            addr_q  <= '0;
            rd_addr <= '0;
            wr_page <= '0;
            wr_off  <= '0;
        end else if (cs_fall) begin
            state   <= ST_CMD;
            bit_cnt <= '0;
            ab_cnt  <= '0;
            sr_have <= 1'b0;
            so_q    <= 1'b0;
        end else if (cs_rise) begin
            state <= ST_IDLE;
            if (wren_ok) wel <= 1'b1;
            if (commit_wr || commit_sr) wel <= 1'b0;
            if (commit_sr) lock_q <= sr_new;
        end else if (!cs_n_s && sck_rise) begin
            sh_in   <= nb[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            unique case (state)
                ST_CMD: if (byte_done) begin
                    unique case (nb)
                        OP_WREN:  state <= ST_WREN;
                        OP_WRDI:  begin wel <= 1'b0; state <= ST_SKIP; end
                        OP_RDSR:  begin tx_sr <= status; state <= ST_RDSR; end
                        OP_WRSR:  state <= ST_WRSR;
                        OP_READ:  begin is_wr <= 1'b0; state <= ST_ADDR; end
                        OP_WRITE: begin is_wr <= 1'b1; state <= ST_ADDR; end
                        default:  state <= ST_SKIP;
                    endcase
                end
                ST_ADDR: begin
                    addr_q <= addr_next[ADDR_W-2:0];
                    ab_cnt <= ab_cnt + 4'd1;
                    if (ab_cnt == 4'd15) begin
                        if (is_wr) begin
                            wr_page <= addr_next[ADDR_W-1:PAGE_W];
                            wr_off  <= addr_next[PAGE_W-1:0];
                            state   <= ST_WDATA;
                        end else begin
                            tx_sr   <= mem[addr_next];
                            rd_addr <= addr_next + 1'b1;
                            state   <= ST_RDATA;
                        end
                    end
                end
                ST_RDATA: if (byte_done) begin
                    tx_sr   <= mem[rd_addr];
                    rd_addr <= rd_addr + 1'b1;
                end
                ST_WDATA: if (byte_done) wr_off <= wr_off + 1'b1;
                ST_RDSR:  if (byte_done) tx_sr <= status;
                ST_WRSR:  if (byte_done) begin
                    sr_new  <= nb[3:2];
                    sr_have <= 1'b1;
                end
                ST_WREN:  state <= ST_SKIP;
                default:  ;
            endcase
        end else if (!cs_n_s && sck_fall) begin
            so_q  <= tx_sr[7];
            tx_sr <= {tx_sr[6:0], 1'b0};
        end
    end

    // Array storage: copies valid buffered bytes into an unprotected page at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (commit_wr && !page_prot) begin
            for (int p = 0; p < PAGE; p++)
                if (pb_valid[p]) mem[{wr_page, PAGE_W'(p)}] <= pb_data[p];
        end
    end
endmodule

// File: rtl/spi_mem_slave_chk.sv
// Protocol checker for spi_mem_slave, attached by bind.
// Assumes the two-stage pin synchronizer of the default configuration.
module spi_mem_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       so_en,
    input logic       so_q,
    input logic       sck_fall,
    input logic       cs_fall,
    input logic       cs_rise,
    input logic       commit_wr,
    input logic       wel,
    input logic [1:0] lock_q
);
    // R2: the serial output bit moves only on a falling clock or frame start.
    a_r2_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_fall) |=> $stable(so_q));

    // R2: output stays disabled while select has been high long enough to pass the synchronizer.
    a_r2_so_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_en);

    // R6: the latch only becomes set at the end of a frame.
    a_r6_wel_set_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise));

    // R10: a committed array write leaves the latch cleared.
    a_r10_wel_clear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> !wel);

    // R12: the lock field changes only when a frame ends.
    a_r12_lock_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(lock_q));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_en(so_en), .so_q(so_q),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .commit_wr(commit_wr), .wel(wel), .lock_q(lock_q)
);

// File: tb/spi_mem_slave_tb.sv
`timescale 1ns/1ps
module spi_mem_slave_tb;
    localparam int HALF  = 6;
    localparam int DEPTH = 64;
    localparam int PAGE  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] mem_m [DEPTH];
    logic       wel_m = 1'b0;
    logic [1:0] lock_m = 2'b00;

    always #2 clk = ~clk;

    spi_mem_slave u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
                         .si(si), .so(so), .so_en(so_en));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic en_all, output logic en_any);
        rx = 8'h00; en_all = 1'b1; en_any = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            si = tx[b];
            wait_clk(HALF);
            rx[b] = so;
            en_all &= so_en;
            en_any |= so_en;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] r; logic a, y;
        xfer(tx, r, a, y);
    endtask

    task automatic bits(input int n);
        for (int b = 0; b < n; b++) begin
            si = 1'b1;
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic fbegin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic fend();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    function automatic bit prot(input int a, input logic [1:0] l);
        case (l)
            2'b00: return 1'b0;
            2'b01: return a >= DEPTH - DEPTH / 4;
            2'b10: return a >= DEPTH / 2;
            default: return 1'b1;
        endcase
    endfunction

    task automatic do_wren();
        fbegin(); send(8'h06); fend();
        wel_m = 1'b1;
    endtask

    task automatic rd_status(input string tag);
        logic [7:0] r; logic a, y;
        fbegin(); send(8'h05);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, r, a, y);
            chk(tag, r, {4'b0, lock_m, wel_m, 1'b0});
        end
        chk({tag, " R2 status output enable"}, {7'b0, a}, 8'h01);
        fend();
    endtask

    task automatic wr_status(input logic [7:0] v);
        fbegin(); send(8'h01); send(v); fend();
        if (wel_m) begin
            lock_m = v[3:2];
            wel_m = 1'b0;
        end
    endtask

    task automatic write_bytes(input int addr, input int n, input int seed);
        logic [7:0] r; logic a, y, any_en;
        any_en = 1'b0;
        fbegin(); send(8'h02); send(8'(addr >> 8)); send(8'(addr));
        for (int k = 0; k < n; k++) begin
            xfer(pat(k, seed), r, a, y);
            any_en |= y;
        end
        fend();
        chk("R2 SO quiet during write", {7'b0, any_en}, 8'h00);
        if (wel_m && n > 0) begin
            for (int k = 0; k < n; k++) begin
                int t;
                t = (addr & ~(PAGE - 1)) | ((addr + k) & (PAGE - 1));
                if (!prot(t, lock_m)) mem_m[t] = pat(k, seed);
            end
            wel_m = 1'b0;
        end
    endtask

    task automatic read_check(input int addr, input int n, input string tag);
        logic [7:0] r; logic a, y;
        fbegin(); send(8'h03); send(8'(addr >> 8)); send(8'(addr));
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r, a, y);
            chk(tag, r, mem_m[(addr + k) % DEPTH]);
            if (!a) chk({tag, " R2 read output enable"}, {7'b0, a}, 8'h01);
        end
        fend();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state.
        chk("R1 so_en after reset", {7'b0, so_en}, 8'h00);
        rd_status("R1 R5 status after reset");
        read_check(0, DEPTH, "R1 array zero");

        // R9: write with latch clear is dropped.
        write_bytes(0, 4, 1);
        read_check(0, 4, "R9 write without latch");

        // R6 R8 R10: fill all pages, latch seen set then cleared.
        for (int pg = 0; pg < 4; pg++) begin
            do_wren();
            rd_status("R6 latch set");
            write_bytes(pg * PAGE, PAGE, pg + 2);
            rd_status("R10 latch cleared by write");
        end
        read_check(0, DEPTH + 3, "R4 R8 full read with wrap");
        read_check(61, 6, "R4 wrap from end");

        // R8: wrap inside page and overlap keeps later byte.
        do_wren(); write_bytes(PAGE + 14, 4, 9);
        do_wren(); write_bytes(2, 20, 10);
        read_check(0, 2 * PAGE, "R8 page wrap and overlap");

        // R6: extra bits or bytes in the enable frame stop the set.
        fbegin(); send(8'h06); bits(1); fend();
        rd_status("R6 nine-bit enable frame");
        fbegin(); send(8'h06); send(8'h00); fend();
        rd_status("R6 enable with trailing byte");

        // R9: malformed write frames keep array and latch.
        do_wren();
        fbegin(); send(8'h02); send(8'h00); send(8'h05); send(8'hAA); bits(3); fend();
        fbegin(); send(8'h02); send(8'h00); fend();
        fbegin(); send(8'h02); send(8'h00); send(8'h10); fend();
        rd_status("R9 latch kept after aborted writes");
        read_check(0, 2 * PAGE, "R9 array kept after aborted writes");

        // R7: latch clear, then write has no effect.
        fbegin(); send(8'h04); fend();
        wel_m = 1'b0;
        rd_status("R7 latch cleared by opcode");
        write_bytes(8, 4, 30);
        read_check(0, PAGE, "R7 write after clear dropped");

        // R3: unknown opcode is ignored.
        begin
            logic [7:0] r; logic a, y;
            fbegin(); send(8'hAB); xfer(8'h00, r, a, y); fend();
            chk("R3 unknown opcode output stays off", {7'b0, y}, 8'h00);
        end
        rd_status("R3 status after unknown opcode");

        // R12: status write without latch is dropped.
        wr_status(8'h0C);
        rd_status("R12 status write without latch");

        // R11 R12: sweep every lock setting over the whole array.
        for (int l = 0; l < 4; l++) begin
            do_wren();
            wr_status({4'hA, 2'(l), 2'b11});
            rd_status("R12 R10 status write");
            for (int pg = 0; pg < 4; pg++) begin
                do_wren();
                write_bytes(pg * PAGE, PAGE, 20 + l * 4 + pg);
            end
            rd_status("R10 latch after locked writes");
            read_check(0, DEPTH, "R11 lock region");
        end

        chk("R2 so_en low at end", {7'b0, so_en}, 8'h00);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule